// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit channel of an interval timer. A host loads an initial count together with a counting mode, and from then on every pulse of the count-enable input `tick` advances the channel by one elapsed tick. Depending on the mode, the `out` pin produces one of several waveforms: a level that rises at terminal count, a one-shot, a periodic rate pulse, a square wave, or a single-tick strobe. The `gate` input either pauses counting or retriggers it, again depending on the mode. The current count value is driven on `count` at all times, so that a host-side wrapper can read it or latch it.

All behaviour is defined in terms of the elapsed ticks `e` since the last load or retrigger, and the loaded count `N`. A loaded value of 0 stands for `N` = 65536. Loading always sets `e` to zero. When a load, a gate retrigger and a tick fall in the same cycle, the load takes precedence, then the retrigger, and the tick is dropped.

A sequencer with four named states drives the terminal-count behaviour:
- `ST_IDLE`: the state after reset.
- `ST_COUNT`: counting towards the terminal count.
- `ST_TERM`: the one tick where `e` equals `N`.
- `ST_DONE`: every tick after that.

The transitions are:
- `restart`: any state to `ST_COUNT`, caused by a load or a gate retrigger.
- `arrive`: `ST_COUNT` to `ST_TERM`, on a counted tick while one tick remains.
- `leave`: `ST_TERM` to `ST_DONE`, on the next counted tick.
- `hold`: `ST_DONE` and `ST_IDLE` stay where they are on a counted tick.

Top module: `pit_channel`

## Requirements
- R1: After reset, `out` is 0, `count` is 0 and the mode is 0. Before the first load, ticks change neither `out` nor `count`.
- R2: A load pulse captures `load_val` and `mode_sel` and sets `e` to 0, so that `count` reads `load_val`. A load in the same cycle as a tick still leaves `e` at 0. A `load_val` of 0 is taken as `N` = 65536: `count` reads 0 and `out` in mode 0 rises only after 65536 ticks.
- R3: In mode 0, `out` = (`e` >= `N`), so it stays high once it has risen. `count` = (`N` - `e`) mod 65536 and keeps wrapping after terminal count.
- R4: In mode 1, `out` = (`e` >= `N`) and `count` = (`N` - `e`) mod 65536.
- R5: In mode 2, `out` = 1 exactly when `e` mod `N` = 0 and `e` != 0. `count` = (`N` - (`e` mod `N`)) mod 65536.
- R6: In mode 3, `out` = 1 when (`e` mod `N`) < ceil(`N`/2). `count` = (`N` - ((2·`e`) mod `N`)) mod 65536.
- R7: In modes 4 and 5, `out` = 1 only in the tick where `e` = `N`. `count` = (`N` - `e`) mod 65536.
- R8: In modes 0 and 4, a tick while `gate` = 0 is not counted. `count` and `out` hold their values, and a rising edge of `gate` does not restart the count.
- R9: In modes 1, 2, 3 and 5, a rising edge of `gate` (a cycle with `gate` = 1 following a cycle with `gate` = 0) sets `e` back to 0, and a tick in that same cycle is dropped. The level of `gate` does not pause counting in these modes.
- R10: Mode codes 6 and 7 behave as modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable pulse, one elapsed tick per high cycle |
| load | input | 1 | Load strobe for `load_val` and `mode_sel` |
| load_val | input | 16 | Initial count (0 means 65536) |
| mode_sel | input | 3 | Counting mode, 0 to 7 |
| gate | input | 1 | Gate: pause in modes 0/4, retrigger on rising edge in others |
| out | output | 1 | Mode-dependent output waveform |
| count | output | 16 | Current count value |

## Verification
Some properties are checked on every clock by the assertions:
- In modes 0 and 1, `out` stays high once it has risen.
- In modes 4 and 5, the strobe lasts a single counted tick.
- In mode 2, the rate pulse drops on the next counted tick.
- In the down-counting modes, `count` falls by exactly one per counted tick.
- With `gate` low in modes 0 and 4, both outputs are frozen.
- A restart always arms the sequencer.

The bench's directed scenarios carry the rest. They check the exact values of the periodic waveforms and counts against an elapsed-tick model, the ceil(`N`/2) high phase for both odd and even counts, the 65536 meaning of a zero load, and the folding of mode codes 6 and 7. They also show precedence within a single cycle: load over retrigger, and retrigger over tick.

// File: rtl/pit_chan_pkg.sv
package pit_chan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_TERM  = 2'd2,
        ST_DONE  = 2'd3
    } tc_state_e;

    typedef enum logic [2:0] {
        MD_LEVEL  = 3'd0,
        MD_SHOT   = 3'd1,
        MD_RATE   = 3'd2,
        MD_SQUARE = 3'd3,
        MD_SWSTB  = 3'd4,
        MD_HWSTB  = 3'd5
    } tc_mode_e;

    // codes 6 and 7 alias the two periodic modes
    function automatic tc_mode_e fold_mode(input logic [2:0] code);
        if (code[2:1] == 2'b11) return tc_mode_e'({1'b0, code[1:0]});
        return tc_mode_e'(code);
    endfunction

    function automatic logic gate_pauses(input tc_mode_e m);
        return (m == MD_LEVEL) || (m == MD_SWSTB);
    endfunction

endpackage

// File: rtl/pit_seq.sv
module pit_seq
    import pit_chan_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          step,
    input  logic [CW:0]   start_val,
    output logic [CW-1:0] down,
    output logic          running,
    output logic          at_term,
    output logic          reached
);
    localparam int NW = CW + 1;

    tc_state_e       state_q, state_d;
    logic [NW-1:0]   left_q;
    logic [CW-1:0]   down_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = ST_COUNT;
        end else if (step) begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_COUNT: state_d = (left_q == NW'(1)) ? ST_TERM : ST_COUNT;
                ST_TERM:  state_d = ST_DONE;
                ST_DONE:  state_d = ST_DONE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            down_q <= '0;
        end else if (restart) begin
            left_q <= start_val;
            down_q <= start_val[CW-1:0];
        end else if (step) begin
            down_q <= down_q - CW'(1);
            if (state_q == ST_COUNT) left_q <= left_q - NW'(1);
        end
    end

    // outputs
    always_comb begin
        down    = down_q;
        running = (state_q != ST_IDLE);
        at_term = (state_q == ST_TERM);
        reached = (state_q == ST_TERM) || (state_q == ST_DONE);
    end

    assert_restart_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (running && !reached));

endmodule

// File: rtl/pit_phase.sv
module pit_phase #(
    parameter int CW = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        step,
    input  logic [CW:0] period,
    output logic [CW:0] phase,
    output logic [CW:0] phase2,
    output logic        started
);
    localparam int NW = CW + 1;

    logic [NW-1:0] ph_q, ph2_q;
    logic          started_q;
    logic [NW-1:0] ph_inc;
    logic [NW:0]   ph2_sum;

    always_comb begin
        ph_inc  = ph_q + NW'(1);
        ph2_sum = {1'b0, ph2_q} + (NW+1)'(2);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            ph_q      <= '0;
            ph2_q     <= '0;
            started_q <= 1'b0;
        end else if (step) begin
            started_q <= 1'b1;
            ph_q      <= (ph_inc == period) ? '0 : ph_inc;
            if (period == NW'(1))
                ph2_q <= '0;
            else if (ph2_sum >= {1'b0, period})
                ph2_q <= NW'(ph2_sum - {1'b0, period});
            else
                ph2_q <= NW'(ph2_sum);
        end
    end

    assign phase   = ph_q;
    assign phase2  = ph2_q;
    assign started = started_q;

    assert_phase_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !restart && period != '0) |=> (ph_q < period));

endmodule

// File: rtl/pit_view.sv
module pit_view
    import pit_chan_pkg::*;
#(
    parameter int CW = 16
) (
    input  tc_mode_e      mode,
    input  logic [CW:0]   period,
    input  logic [CW-1:0] down,
    input  logic          running,
    input  logic          at_term,
    input  logic          reached,
    input  logic [CW:0]   phase,
    input  logic [CW:0]   phase2,
    input  logic          started,
    output logic          out,
    output logic [CW-1:0] count
);
    localparam int NW = CW + 1;

    logic [NW-1:0] half;
    logic [NW-1:0] rate_left, sq_left;

    always_comb begin
        half      = NW'(({1'b0, period} + (NW+1)'(1)) >> 1);
        rate_left = period - phase;
        sq_left   = period - phase2;
        out       = 1'b0;
        count     = down;
        unique case (mode)
            MD_LEVEL, MD_SHOT: out = reached;
            MD_RATE: begin
                out   = started && (phase == '0);
                count = rate_left[CW-1:0];
            end
            MD_SQUARE: begin
                out   = running && (phase < half);
                count = sq_left[CW-1:0];
            end
            MD_SWSTB, MD_HWSTB: out = at_term;
            default: out = 1'b0;
        endcase
    end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_chan_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic [2:0]    mode_sel,
    input  logic          gate,
    output logic          out,
    output logic [CW-1:0] count
);
    localparam int NW = CW + 1;

    tc_mode_e      mode_q;
    logic [NW-1:0] period_q;
    logic          gate_q;
    logic [NW-1:0] load_n, start_val;
    logic          restart, step, retrig;
    logic [CW-1:0] down;
    logic          running, at_term, reached, started;
    logic [NW-1:0] phase, phase2;

    always_comb begin
        load_n    = (load_val == '0) ? (NW'(1) << CW) : {1'b0, load_val};
        retrig    = gate && !gate_q && running && !gate_pauses(mode_q);
        restart   = load || retrig;
        start_val = load ? load_n : period_q;
        step      = tick && running && !restart && (gate || !gate_pauses(mode_q));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MD_LEVEL;
            period_q <= '0;
            gate_q   <= 1'b0;
        end else begin
            gate_q <= gate;
            if (load) begin
                mode_q   <= fold_mode(mode_sel);
                period_q <= load_n;
            end
        end
    end

    pit_seq #(.CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .restart(restart), .step(step),
        .start_val(start_val), .down(down), .running(running),
        .at_term(at_term), .reached(reached)
    );

    pit_phase #(.CW(CW)) u_phase (
        .clk(clk), .rst_n(rst_n), .restart(restart), .step(step),
        .period(period_q), .phase(phase), .phase2(phase2), .started(started)
    );

    pit_view #(.CW(CW)) u_view (
        .mode(mode_q), .period(period_q), .down(down), .running(running),
        .at_term(at_term), .reached(reached), .phase(phase), .phase2(phase2),
        .started(started), .out(out), .count(count)
    );

    assert_level_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MD_LEVEL || mode_q == MD_SHOT) && out && !restart) |=> out);

    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MD_SWSTB || mode_q == MD_HWSTB) && out && step) |=> !out);

    assert_rate_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_RATE && out && step && period_q != NW'(1)) |=> !out);

    assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MD_LEVEL || mode_q == MD_SHOT || mode_q == MD_SWSTB ||
          mode_q == MD_HWSTB) && step) |=> (count == $past(count) - CW'(1)));

    assert_gate_pause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_pauses(mode_q) && running && !gate && !load) |=> ($stable(count) && $stable(out)));

endmodule

// File: tb/pit_channel_bench.sv
module pit_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        load = 1'b0;
    logic [15:0] load_val = '0;
    logic [2:0]  mode_sel = '0;
    logic        gate = 1'b0;
    logic        out;
    logic [15:0] count;

    int checks = 0;
    int errors = 0;

    // bench model state
    int  md = 0;
    int  nn = 0;
    longint e = 0;
    bit  armed = 0;
    bit  gprev = 0;

    always #5 clk = ~clk;

    pit_channel u_pit_channel (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .load_val(load_val),
        .mode_sel(mode_sel), .gate(gate), .out(out), .count(count)
    );

    function automatic int fold(input int m);
        return (m >= 6) ? m - 4 : m;
    endfunction

    function automatic bit exp_out();
        if (!armed) return 1'b0;
        case (md)
            0, 1:    return e >= nn;
            2:       return (e % nn == 0) && (e != 0);
            3:       return (e % nn) < ((nn + 1) / 2);
            default: return e == nn;
        endcase
    endfunction

    function automatic int exp_cnt();
        if (!armed) return 0;
        case (md)
            2:       return int'((nn - (e % nn)) & 16'hFFFF);
            3:       return int'((nn - ((2 * e) % nn)) & 16'hFFFF);
            default: return int'((nn - e) & 16'hFFFF);
        endcase
    endfunction

    task automatic check(input string tag);
        bit eo;
        int ec;
        eo = exp_out();
        ec = exp_cnt();
        checks++;
        if (out !== eo || int'(count) !== ec) begin
            errors++;
            $display("FAIL %s mode=%0d N=%0d e=%0d: out=%b count=%0d expected out=%b count=%0d",
                     tag, md, nn, e, out, count, eo, ec);
        end
    endtask

    task automatic cyc(input logic t, input logic g);
        bit rise;
        tick = t;
        gate = g;
        rise = g && !gprev;
        @(posedge clk); #1;
        if (armed && rise && !(md == 0 || md == 4)) e = 0;
        else if (armed && t && (g || !(md == 0 || md == 4))) e++;
        gprev = g;
        tick = 1'b0;
    endtask

    task automatic do_load(input int m, input int v, input logic t);
        load = 1'b1; load_val = 16'(v); mode_sel = 3'(m); tick = t;
        @(posedge clk); #1;
        load = 1'b0; tick = 1'b0;
        md = fold(m); nn = (v == 0) ? 65536 : v; e = 0; armed = 1;
        gprev = gate;
    endtask

    task automatic run(input int k, input string tag);
        for (int i = 0; i < k; i++) begin
            cyc(1'b1, gate);
            check(tag);
        end
    endtask

    task automatic t_reset();
        check("R1");
        for (int i = 0; i < 3; i++) begin cyc(1'b1, 1'b1); check("R1"); end
    endtask

    task automatic t_mode0();
        do_load(0, 5, 1'b1); check("R2");
        run(8, "R3");
        cyc(1'b0, 1'b1); check("R3");
    endtask

    task automatic t_gate_pause();
        do_load(0, 6, 1'b0); check("R2");
        run(2, "R3");
        for (int i = 0; i < 3; i++) begin cyc(1'b1, 1'b0); check("R8"); end
        cyc(1'b1, 1'b1); check("R8");
        run(5, "R8");
        do_load(4, 3, 1'b0);
        cyc(1'b1, 1'b0); check("R8");
        cyc(1'b1, 1'b1); check("R8");
        run(4, "R7");
    endtask

    task automatic t_mode1();
        do_load(1, 4, 1'b0); check("R2");
        run(6, "R4");
        cyc(1'b1, 1'b0); check("R9");
        cyc(1'b1, 1'b1); check("R9");
        run(5, "R4");
    endtask

    task automatic t_rate();
        do_load(2, 3, 1'b0); run(10, "R5");
        cyc(1'b0, 1'b0); check("R9");
        cyc(1'b1, 1'b1); check("R9");
        run(4, "R5");
        do_load(2, 1, 1'b0); run(3, "R5");
    endtask

    task automatic t_square();
        do_load(3, 5, 1'b0); run(12, "R6");
        do_load(3, 4, 1'b0); run(9, "R6");
        cyc(1'b1, 1'b0); check("R9");
        cyc(1'b1, 1'b1); check("R9");
        run(3, "R6");
    endtask

    task automatic t_strobe();
        do_load(4, 3, 1'b0); run(6, "R7");
        do_load(5, 2, 1'b0); run(4, "R7");
        cyc(1'b1, 1'b0); check("R9");
        cyc(1'b1, 1'b1); check("R9");
        run(4, "R7");
    endtask

    task automatic t_alias();
        do_load(6, 4, 1'b0); run(9, "R10");
        do_load(7, 3, 1'b0); run(7, "R10");
    endtask

    task automatic t_zero();
        do_load(1, 9, 1'b0); run(3, "R4");
        do_load(0, 0, 1'b1); check("R2");
        for (int i = 0; i < 65535; i++) cyc(1'b1, 1'b1);
        check("R2");
        run(2, "R2");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R1..all actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_mode0();
        t_gate_pause();
        t_mode1();
        t_rate();
        t_square();
        t_strobe();
        t_alias();
        t_zero();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule